// File: doc/BRIEF.md
# Pin Event Detector

This block watches the input pins of a parameterizable port (32 by default) and turns pin activity into status flags, a combined interrupt line, a combined DMA request line and per-pin trigger outputs. Each pin has its own 4-bit mode code. The code chooses how the pin behaves: it can be ignored, request DMA on an edge, record an edge in a flag only, raise an interrupt on an edge or a level, or drive a trigger output from its synchronized state.

Each pin first passes through a two-stage synchronizer. Edges are found by comparing the synchronized sample with the sample from the previous cycle. A detected event sets the pin's bit in the status vector. Software clears status bits by writing ones through a mask strobe. A DMA acknowledge clears every flag whose pin is in a DMA mode. Pin muxing and interrupt prioritization are handled by neighbouring logic.

Top module: `pin_event_detector`

## Requirements
- R1: Mode code 0 makes the pin inert: edges and levels on it set no flag and raise neither `irqOut` nor `dmaReq`.
- R2: Codes 1, 2 and 3 set the flag on a rising edge, a falling edge, or either edge. A set flag on a pin with one of these codes drives `dmaReq` high, and such a pin never drives `irqOut`.
- R3: Codes 5, 6 and 7 set the flag on a rising edge, a falling edge, or either edge. These codes raise neither `irqOut` nor `dmaReq`.
- R4: Codes 9, 10 and 11 set the flag on a rising edge, a falling edge, or either edge. A set flag on a pin with one of these codes drives `irqOut` high.
- R5: Code 8 sets the flag on every cycle in which the synchronized pin is 0. Code 12 does the same when the pin is 1. Both drive `irqOut`. Because of this, clearing the flag while the level is still present leaves it set.
- R6: Code 13 drives `trigOut[i]` equal to the synchronized pin. Code 14 drives it inverted. These codes set no flag. With any other code, `trigOut[i]` is 0.
- R7: Pulsing `clrWe` clears the status bits where `clrMask` is 1, at that clock edge. Bits where `clrMask` is 0 keep their value.
- R8: Pulsing `dmaAck` clears, at that clock edge, the flags of all pins whose code is 1, 2 or 3. It leaves all other flags unchanged.
- R9: When a set event and a clear reach the same bit in the same cycle, the bit stays set.
- R10: A pin change becomes visible in `statusFlags` after the third rising clock edge following the change: two edges for synchronization and one for the flag register.
- R11: After reset, `statusFlags`, `irqOut`, `dmaReq` and `trigOut` are all 0 while every mode code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| modeCfg | input | NUM_PINS*4 | Mode code per pin; pin i uses bits [4i+3:4i] |
| clrWe | input | 1 | Write strobe for the clear mask |
| clrMask | input | NUM_PINS | Ones clear the matching status bits |
| dmaAck | input | 1 | DMA transfer done; clears the flags of DMA-mode pins |
| statusFlags | output | NUM_PINS | Per-pin event flags |
| irqOut | output | 1 | OR of the flags of interrupt-mode pins |
| dmaReq | output | 1 | OR of the flags of DMA-mode pins |
| trigOut | output | NUM_PINS | Per-pin trigger outputs |

## Verification
The assertions check the following on every cycle:
- the flag register's update rule: set wins, clears are honoured, and bits hold otherwise;
- the one-cycle relation between the current and previous samples;
- the immediate re-set of a flag for a level-mode pin whose level is still present.

Only the bench scenarios can show the end-to-end behaviour:
- the exact three-edge latency from a pin to its flag;
- the edge polarity of each mode group;
- that a DMA acknowledge spares flag-only pins;
- that trigger and inert modes never touch the flags.

// File: rtl/ped_pkg.sv
package ped_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF      = 4'd0,
    MODE_DMA_RISE = 4'd1,
    MODE_DMA_FALL = 4'd2,
    MODE_DMA_ANY  = 4'd3,
    MODE_FLG_RISE = 4'd5,
    MODE_FLG_FALL = 4'd6,
    MODE_FLG_ANY  = 4'd7,
    MODE_IRQ_LOW  = 4'd8,
    MODE_IRQ_RISE = 4'd9,
    MODE_IRQ_FALL = 4'd10,
    MODE_IRQ_ANY  = 4'd11,
    MODE_IRQ_HIGH = 4'd12,
    MODE_TRG_HIGH = 4'd13,
    MODE_TRG_LOW  = 4'd14
  } pinMode_e;

  // Strobes from control to datapath, one per pin.
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } pinStrobe_t;

  function automatic logic modeIsDma(input logic [MODE_W-1:0] m);
    return (m == MODE_DMA_RISE) || (m == MODE_DMA_FALL) || (m == MODE_DMA_ANY);
  endfunction

  function automatic logic modeIsIrq(input logic [MODE_W-1:0] m);
    return (m >= MODE_IRQ_LOW) && (m <= MODE_IRQ_HIGH);
  endfunction

  // Event for a pin given its mode and the current/previous samples.
  function automatic logic modeEvent(input logic [MODE_W-1:0] m,
                                     input logic cur, input logic prev);
    logic rise;
    logic fall;
    logic ev;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (m)
      MODE_DMA_RISE, MODE_FLG_RISE, MODE_IRQ_RISE: ev = rise;
      MODE_DMA_FALL, MODE_FLG_FALL, MODE_IRQ_FALL: ev = fall;
      MODE_DMA_ANY,  MODE_FLG_ANY,  MODE_IRQ_ANY:  ev = rise | fall;
      MODE_IRQ_LOW:  ev = ~cur;
      MODE_IRQ_HIGH: ev = cur;
      default:       ev = 1'b0;
    endcase
    return ev;
  endfunction
endpackage

// File: rtl/ped_datapath.sv
module ped_datapath
  import ped_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PINS-1:0]       pinIn,
  input  pinStrobe_t [NUM_PINS-1:0] strobes,
  output logic [NUM_PINS-1:0]       curLvl,
  output logic [NUM_PINS-1:0]       prevLvl,
  output logic [NUM_PINS-1:0]       status
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign curLvl = syncChain[LAST_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= curLvl;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   status[i] <= 1'b0;
      else if (strobes[i].setFlag) status[i] <= 1'b1;
      else if (strobes[i].clrFlag) status[i] <= 1'b0;
    end

    // A set strobe always leaves the flag set, even against a clear.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobes[i].setFlag |=> status[i]);

    // A clear with no competing set empties the flag.
    assert_clear_applies_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].clrFlag && !strobes[i].setFlag) |=> !status[i]);

    // Without strobes the flag holds its value.
    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[i].clrFlag && !strobes[i].setFlag) |=> $stable(status[i]));
  end

  // The previous sample trails the current sample by one cycle.
  assert_prev_trails_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (prevLvl == $past(curLvl)));
endmodule

// File: rtl/ped_ctrl.sv
module ped_ctrl
  import ped_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS*MODE_W-1:0] modeCfg,
  input  logic [NUM_PINS-1:0]        curLvl,
  input  logic [NUM_PINS-1:0]        prevLvl,
  input  logic [NUM_PINS-1:0]        status,
  input  logic                       clrWe,
  input  logic [NUM_PINS-1:0]        clrMask,
  input  logic                       dmaAck,
  output pinStrobe_t [NUM_PINS-1:0]  strobes,
  output logic                       irqOut,
  output logic                       dmaReq,
  output logic [NUM_PINS-1:0]        trigOut
);
  logic [NUM_PINS-1:0] dmaSel;
  logic [NUM_PINS-1:0] irqSel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic [MODE_W-1:0] pinMode;
    assign pinMode = modeCfg[i*MODE_W +: MODE_W];

    always_comb begin
      dmaSel[i] = modeIsDma(pinMode);
      irqSel[i] = modeIsIrq(pinMode);
      strobes[i].setFlag = modeEvent(pinMode, curLvl[i], prevLvl[i]);
      strobes[i].clrFlag = (clrWe & clrMask[i]) | (dmaAck & dmaSel[i]);
      case (pinMode)
        MODE_TRG_HIGH: trigOut[i] = curLvl[i];
        MODE_TRG_LOW:  trigOut[i] = ~curLvl[i];
        default:       trigOut[i] = 1'b0;
      endcase
    end

    // A flag in high-level mode is re-set after any clear while the level stays.
    assert_level_reasserts_R5: assert property (@(posedge clk) disable iff (!rstN)
      (pinMode == MODE_IRQ_HIGH && curLvl[i] && clrWe && clrMask[i]) |=> status[i]);
  end

  assign irqOut = |(status & irqSel);
  assign dmaReq = |(status & dmaSel);

  // Requests only exist while some flag is set.
  assert_req_needs_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || dmaReq) |-> (status != '0));
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import ped_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [NUM_PINS*MODE_W-1:0] modeCfg,
  input  logic                       clrWe,
  input  logic [NUM_PINS-1:0]        clrMask,
  input  logic                       dmaAck,
  output logic [NUM_PINS-1:0]        statusFlags,
  output logic                       irqOut,
  output logic                       dmaReq,
  output logic [NUM_PINS-1:0]        trigOut
);
  pinStrobe_t [NUM_PINS-1:0] strobes;
  logic [NUM_PINS-1:0] curLvl;
  logic [NUM_PINS-1:0] prevLvl;

  ped_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobes(strobes),
    .curLvl(curLvl), .prevLvl(prevLvl), .status(statusFlags)
  );

  ped_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .clk(clk), .rstN(rstN), .modeCfg(modeCfg), .curLvl(curLvl),
    .prevLvl(prevLvl), .status(statusFlags), .clrWe(clrWe),
    .clrMask(clrMask), .dmaAck(dmaAck), .strobes(strobes),
    .irqOut(irqOut), .dmaReq(dmaReq), .trigOut(trigOut)
  );
endmodule

// File: tb/sim_pin_event_detector.sv
module sim_pin_event_detector;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [3:0] modes [NP];
  logic [NP*4-1:0] modeCfg;
  logic clrWe = 1'b0;
  logic [NP-1:0] clrMask = '0;
  logic dmaAck = 1'b0;
  logic [NP-1:0] statusFlags;
  logic irqOut;
  logic dmaReq;
  logic [NP-1:0] trigOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    logic [NP-1:0] st;
    logic irq;
    logic dma;
    logic [NP-1:0] trg;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < NP; i++) modeCfg[i*4 +: 4] = modes[i];

  pin_event_detector u0 (
    .clk(clk), .rstN(rstN), .pinIn(pins), .modeCfg(modeCfg), .clrWe(clrWe),
    .clrMask(clrMask), .dmaAck(dmaAck), .statusFlags(statusFlags),
    .irqOut(irqOut), .dmaReq(dmaReq), .trigOut(trigOut)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_state(input string tag, input logic [NP-1:0] st,
                              input logic irq, input logic dma,
                              input logic [NP-1:0] trg);
    expItem_t it;
    it.tag = tag; it.st = st; it.irq = irq; it.dma = dma; it.trg = trg;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic clear(input logic [NP-1:0] m);
    clrMask = m; clrWe = 1'b1;
    step(1);
    clrWe = 1'b0; clrMask = '0;
  endtask

  // Monitor: compare outputs against queued expectations away from the edge.
  initial forever begin
    @(negedge clk);
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (statusFlags !== it.st || irqOut !== it.irq || dmaReq !== it.dma ||
          trigOut !== it.trg) begin
        errors++;
        $display("FAIL %s: got st=%h irq=%b dma=%b trg=%h exp st=%h irq=%b dma=%b trg=%h",
                 it.tag, statusFlags, irqOut, dmaReq, trigOut,
                 it.st, it.irq, it.dma, it.trg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) modes[i] = 4'd0;
    step(3);
    rstN = 1'b1;
    step(2);
    expect_state("R11 reset state", '0, 0, 0, '0);

    // R10 latency and R4 rising-edge interrupt on pin 0
    modes[0] = 4'd9;
    step(1);
    pins[0] = 1'b1;
    step(2);
    expect_state("R10 no flag before third edge", '0, 0, 0, '0);
    step(0);
    @(posedge clk); #1;
    expect_state("R10 R4 flag after third edge", 32'h1, 1, 0, '0);

    // R7 write-zero and write-one clear
    clear(32'h0);
    expect_state("R7 zero mask keeps flag", 32'h1, 1, 0, '0);
    clear(32'h1);
    expect_state("R7 one mask clears flag", '0, 0, 0, '0);

    // R4 falling and either edge
    modes[1] = 4'd10; modes[12] = 4'd11;
    pins[1] = 1'b1; pins[12] = 1'b1;
    step(4);
    expect_state("R4 rise on any-edge pin only", 32'h1000, 1, 0, '0);
    pins[1] = 1'b0; pins[12] = 1'b0;
    step(4);
    expect_state("R4 falling edge flags", 32'h1002, 1, 0, '0);
    clear('1);
    expect_state("R7 clear all", '0, 0, 0, '0);

    // R1 inert pin
    pins[2] = 1'b1; step(4);
    pins[2] = 1'b0; step(4);
    expect_state("R1 mode 0 ignores toggles", '0, 0, 0, '0);

    // R2 DMA edges, R3 flag-only, R8 acknowledge
    modes[3] = 4'd1; modes[4] = 4'd2; modes[5] = 4'd3;
    modes[6] = 4'd7; modes[7] = 4'd5;
    pins[7:3] = 5'b11111;
    step(4);
    expect_state("R2 R3 rising edges", 32'hE8, 0, 1, '0);
    pins[7:3] = 5'b00000;
    step(4);
    expect_state("R2 R3 falling edges", 32'hF8, 0, 1, '0);
    dmaAck = 1'b1; step(1); dmaAck = 1'b0;
    expect_state("R8 ack clears DMA flags only", 32'hC0, 0, 0, '0);
    expect_state("R3 flag-only raises nothing", 32'hC0, 0, 0, '0);
    clear('1);

    // R5 high level with clear while asserted
    modes[8] = 4'd12;
    pins[8] = 1'b1;
    step(4);
    expect_state("R5 high level sets flag", 32'h100, 1, 0, '0);
    clear(32'h100);
    expect_state("R5 flag re-set while level held", 32'h100, 1, 0, '0);
    pins[8] = 1'b0;
    step(4);
    clear(32'h100);
    expect_state("R5 clear after level gone", '0, 0, 0, '0);

    // R5 low level
    modes[9] = 4'd8;
    step(2);
    expect_state("R5 low level sets flag", 32'h200, 1, 0, '0);
    pins[9] = 1'b1;
    step(4);
    clear(32'h200);
    step(2);
    expect_state("R5 low level flag stays clear", '0, 0, 0, '0);

    // R9 set wins over a same-cycle clear
    pins[0] = 1'b0;
    step(4);
    pins[0] = 1'b1;
    step(2);
    clear(32'h1);
    expect_state("R9 set beats clear", 32'h1, 1, 0, '0);
    clear(32'h1);

    // R6 trigger outputs
    modes[10] = 4'd13; modes[11] = 4'd14;
    step(1);
    expect_state("R6 trigger idle levels", '0, 0, 0, 32'h800);
    pins[10] = 1'b1; pins[11] = 1'b1;
    step(1);
    expect_state("R6 trigger after one edge", '0, 0, 0, 32'h800);
    step(1);
    expect_state("R6 trigger follows sync pin", '0, 0, 0, 32'h400);

    step(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule